// File: doc/BRIEF.md
# Stack Sequencer for Push, Pull, Call and Return

This block carries out the stack side of an 8-bit processor's push, pull, call, return and software-break operations. The stack is descending and lives in one fixed page of the 16-bit address space. The stack pointer is 8 bits wide. The processor core presents the current stack pointer, accumulator, status byte and program counter, selects an operation and pulses `start`. The sequencer then makes one memory access per clock on a byte-wide port. It reports the new stack pointer, accumulator, status byte and program counter together with a one-cycle `done`.

The core fetches and decodes instructions and keeps its registers itself. It copies the results back on `done`. Because the block snapshots every input at `start`, the core may change those inputs while the sequence runs. The block has no hardware interrupt entry. It handles only the sequence triggered by the break instruction.

Top module: `stk_call_unit`

## Requirements
- R1: A byte push writes to address 0x0100 + SP and then lowers SP by one modulo 256, so a push at SP = 0x00 writes 0x0100 and leaves SP = 0xFF. Operation 0 pushes the accumulator.
- R2: A byte pull first raises SP by one modulo 256 and then reads 0x0100 + SP, so a pull at SP = 0xFF reads 0x0100 and leaves SP = 0x00. The port never asserts read and write together.
- R3: Operation 1 pushes the status byte with bits 5 and 4 forced to 1. The status result is the unmodified input.
- R4: Operation 2 pulls into the accumulator. It sets status bit 7 (N) to bit 7 of the byte and status bit 1 (Z) to 1 exactly when the byte is zero, and leaves the other status bits unchanged. Operation 3 loads the pulled byte into the status result as it is.
- R5: Operation 4 (call) pushes `pc_in` minus one, high byte first and then low byte. It leaves SP two lower and sets the program counter result to `target`.
- R6: Operation 5 (return from subroutine) pulls the low byte and then the high byte. It sets the program counter result to that word plus one, modulo 65536.
- R7: Operation 6 (return from interrupt) pulls the status byte, then the low byte, then the high byte of the program counter, and applies no increment.
- R8: Operation 7 (break) does the following:
  - It pushes `pc_in` plus one, high byte and then low byte.
  - It then pushes the status byte with bit 2 (interrupt disable) set and bits 5 and 4 forced to 1.
  - It reads 0xFFFE (low) and then 0xFFFF (high) as the new program counter.
  - Its status result has bit 2 set and SP ends three lower.
- R9: The block makes exactly one memory access per clock, starting in the cycle after `start` is taken. `done` is high for one cycle, in the cycle after the final access, and the results are valid in that cycle.
- R10: `start` is ignored while the block is busy. The running sequence and its results are unchanged by new `start`, `op` or data inputs.
- R11: After synchronous reset the block is idle, with `busy`, `done`, `mem_we` and `mem_re` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin the selected operation when idle |
| op | input | 3 | Operation: 0 push A, 1 push status, 2 pull A, 3 pull status, 4 call, 5 return-sub, 6 return-int, 7 break |
| sp_in | input | 8 | Current stack pointer |
| acc_in | input | 8 | Current accumulator |
| stat_in | input | 8 | Current status byte |
| pc_in | input | 16 | Address of the next instruction |
| target | input | 16 | Call destination |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse; results valid |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write strobe for this cycle |
| mem_re | output | 1 | Read strobe for this cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle of the read |
| sp_out | output | 8 | New stack pointer |
| acc_out | output | 8 | New accumulator |
| stat_out | output | 8 | New status byte |
| pc_out | output | 16 | New program counter |

## Verification
Each operation runs against a memory model that checks the order of every access and the exact address and data of each write. A call followed by a return shows the minus-one/plus-one pairing. A separate return at 0xFFFF shows the 16-bit wrap. Pulls of 0x80 and 0x00 into the accumulator separate the N update from the Z update, and a pull at SP = 0xFF against a push at SP = 0x00 shows the wrap in each direction. A break holds `start` high with a different operation while it runs, which shows that the sequence ignores a restart.

// File: rtl/stk_pkg.sv
// Shared types for the stack sequencer: operation codes and the kinds of
// memory access that a sequence is built from.
package stk_pkg;

    typedef enum logic [2:0] {
        OP_PUSH_A   = 3'd0,
        OP_PUSH_S   = 3'd1,
        OP_PULL_A   = 3'd2,
        OP_PULL_S   = 3'd3,
        OP_CALL     = 3'd4,
        OP_RET_SUB  = 3'd5,
        OP_RET_INT  = 3'd6,
        OP_BREAK    = 3'd7
    } stk_op_e;

    typedef enum logic [3:0] {
        AK_NONE,
        AK_WR_ACC,
        AK_WR_STAT,
        AK_WR_RETH,
        AK_WR_RETL,
        AK_RD_ACC,
        AK_RD_STAT,
        AK_RD_PCL,
        AK_RD_PCH,
        AK_RD_VECL,
        AK_RD_VECH
    } acc_kind_e;

    localparam int STEP_W = 3;

endpackage

// File: rtl/stk_plan.sv
// Sequence plan: maps an operation and a step index to the access made in
// that step, and flags the final step. Purely combinational.
// Assumes the step index starts at 0 and rises by one per access.
module stk_plan
    import stk_pkg::*;
(
    input  stk_op_e                 op,
    input  logic [STEP_W-1:0]       step,
    output acc_kind_e               kind,
    output logic                    last
);

    // Choose the access for this operation and step.
    always_comb begin
        kind = AK_NONE;
        last = 1'b1;
        unique case (op)
            OP_PUSH_A:  kind = AK_WR_ACC;
            OP_PUSH_S:  kind = AK_WR_STAT;
            OP_PULL_A:  kind = AK_RD_ACC;
            OP_PULL_S:  kind = AK_RD_STAT;
            OP_CALL: begin
                kind = (step == 3'd0) ? AK_WR_RETH : AK_WR_RETL;
                last = (step == 3'd1);
            end
            OP_RET_SUB: begin
                kind = (step == 3'd0) ? AK_RD_PCL : AK_RD_PCH;
                last = (step == 3'd1);
            end
            OP_RET_INT: begin
                case (step)
                    3'd0:    kind = AK_RD_STAT;
                    3'd1:    kind = AK_RD_PCL;
                    default: kind = AK_RD_PCH;
                endcase
                last = (step == 3'd2);
            end
            OP_BREAK: begin
                case (step)
                    3'd0:    kind = AK_WR_RETH;
                    3'd1:    kind = AK_WR_RETL;
                    3'd2:    kind = AK_WR_STAT;
                    3'd3:    kind = AK_RD_VECL;
                    default: kind = AK_RD_VECH;
                endcase
                last = (step == 3'd4);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stk_addr.sv
// Address generator: turns an access kind and the current stack pointer into
// the memory address, the strobes and the stack pointer after the access.
// Assumes a descending stack: pushes use SP then decrement, pulls increment
// then use SP. Vector reads leave SP alone.
module stk_addr
    import stk_pkg::*;
#(
    parameter int                          ADDR_W     = 16,
    parameter int                          SP_W       = 8,
    parameter logic [ADDR_W-SP_W-1:0]      STACK_PAGE = 1,
    parameter logic [ADDR_W-1:0]           VEC_ADDR   = 16'hFFFE
) (
    input  acc_kind_e              kind,
    input  logic [SP_W-1:0]        sp,
    output logic [ADDR_W-1:0]      addr,
    output logic                   we,
    output logic                   re,
    output logic [SP_W-1:0]        sp_nxt
);

    localparam logic [SP_W-1:0]   SP_ONE  = 1;
    localparam logic [ADDR_W-1:0] VEC_HI  = VEC_ADDR + ADDR_W'(1);

    logic is_wr, is_pull, is_vec;
    logic [SP_W-1:0] sp_inc, sp_dec;

    // Classify the access.
    always_comb begin
        is_wr   = (kind == AK_WR_ACC) || (kind == AK_WR_STAT) ||
                  (kind == AK_WR_RETH) || (kind == AK_WR_RETL);
        is_pull = (kind == AK_RD_ACC) || (kind == AK_RD_STAT) ||
                  (kind == AK_RD_PCL) || (kind == AK_RD_PCH);
        is_vec  = (kind == AK_RD_VECL) || (kind == AK_RD_VECH);
    end

    // Form the address, the strobes and the next stack pointer.
    always_comb begin
        sp_inc = sp + SP_ONE;
        sp_dec = sp - SP_ONE;
        if (is_vec)
            addr = (kind == AK_RD_VECH) ? VEC_HI : VEC_ADDR;
        else
            addr = {STACK_PAGE, (is_pull ? sp_inc : sp)};
        we     = is_wr;
        re     = is_pull || is_vec;
        sp_nxt = is_wr ? sp_dec : (is_pull ? sp_inc : sp);
    end

    // R2
    always_comb begin
        strobe_excl_chk: assert (!(we && re));
    end

endmodule

// File: rtl/stk_call_unit.sv
// Stack sequencer top. Snapshots the core's SP, A, status and PC on start,
// runs the selected push/pull/call/return/break sequence with one memory
// access per clock, and presents the results with a one-cycle done pulse.
// Assumes memory read data is valid in the same cycle as the read strobe.
module stk_call_unit
    import stk_pkg::*;
#(
    parameter int                          ADDR_W     = 16,
    parameter int                          SP_W       = 8,
    parameter int                          DATA_W     = 8,
    parameter logic [ADDR_W-SP_W-1:0]      STACK_PAGE = 1,
    parameter logic [ADDR_W-1:0]           VEC_ADDR   = 16'hFFFE,
    parameter int                          I_BIT      = 2,
    parameter int                          Z_BIT      = 1,
    parameter int                          N_BIT      = 7,
    parameter logic [DATA_W-1:0]           FORCE_MASK = 8'h30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           op,
    input  logic [SP_W-1:0]      sp_in,
    input  logic [DATA_W-1:0]    acc_in,
    input  logic [DATA_W-1:0]    stat_in,
    input  logic [ADDR_W-1:0]    pc_in,
    input  logic [ADDR_W-1:0]    target,
    output logic                 busy,
    output logic                 done,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [SP_W-1:0]      sp_out,
    output logic [DATA_W-1:0]    acc_out,
    output logic [DATA_W-1:0]    stat_out,
    output logic [ADDR_W-1:0]    pc_out
);

    localparam logic [ADDR_W-1:0] PC_ONE = 1;
    localparam int                HALF   = ADDR_W / 2;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_e;

    seq_state_e           state_q;
    stk_op_e              op_q;
    logic [STEP_W-1:0]    step_q;
    logic [SP_W-1:0]      sp_q;
    logic [DATA_W-1:0]    acc_q, stat_q;
    logic [ADDR_W-1:0]    pc_q, ret_q;

    acc_kind_e            plan_kind, kind;
    logic                 plan_last;
    logic [SP_W-1:0]      sp_nxt;
    logic                 running;

    assign running = (state_q == ST_RUN);

    stk_plan u_plan (
        .op   (op_q),
        .step (step_q),
        .kind (plan_kind),
        .last (plan_last)
    );

    // Only the running state makes an access.
    assign kind = running ? plan_kind : AK_NONE;

    stk_addr #(
        .ADDR_W     (ADDR_W),
        .SP_W       (SP_W),
        .STACK_PAGE (STACK_PAGE),
        .VEC_ADDR   (VEC_ADDR)
    ) u_addr (
        .kind   (kind),
        .sp     (sp_q),
        .addr   (mem_addr),
        .we     (mem_we),
        .re     (mem_re),
        .sp_nxt (sp_nxt)
    );

    // Select the byte driven on a write.
    always_comb begin
        unique case (kind)
            AK_WR_ACC:  mem_wdata = acc_q;
            AK_WR_STAT: mem_wdata = stat_q | FORCE_MASK;
            AK_WR_RETH: mem_wdata = ret_q[ADDR_W-1:HALF];
            AK_WR_RETL: mem_wdata = ret_q[HALF-1:0];
            default:    mem_wdata = '0;
        endcase
    end

    // Control: idle, running steps, one done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PUSH_A;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    op_q    <= stk_op_e'(op);
                    step_q  <= '0;
                end
                ST_RUN: begin
                    step_q <= step_q + 1'b1;
                    if (plan_last) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Data: snapshot inputs on start, fold in read data while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= '0;
            acc_q  <= '0;
            stat_q <= '0;
            pc_q   <= '0;
            ret_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                sp_q   <= sp_in;
                acc_q  <= acc_in;
                stat_q <= stat_in;
                if (op == OP_BREAK) stat_q[I_BIT] <= 1'b1;
                pc_q   <= (op == OP_CALL) ? target : pc_in;
                ret_q  <= (op == OP_BREAK) ? pc_in + PC_ONE : pc_in - PC_ONE;
            end
        end else if (running) begin
            sp_q <= sp_nxt;
            unique case (kind)
                AK_RD_ACC: begin
                    acc_q         <= mem_rdata;
                    stat_q[N_BIT] <= mem_rdata[DATA_W-1];
                    stat_q[Z_BIT] <= (mem_rdata == '0);
                end
                AK_RD_STAT: stat_q <= mem_rdata;
                AK_RD_PCL, AK_RD_VECL: pc_q[HALF-1:0] <= mem_rdata;
                AK_RD_PCH, AK_RD_VECH: begin
                    if (op_q == OP_RET_SUB)
                        pc_q <= {mem_rdata, pc_q[HALF-1:0]} + PC_ONE;
                    else
                        pc_q[ADDR_W-1:HALF] <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign sp_out   = sp_q;
    assign acc_out  = acc_q;
    assign stat_out = stat_q;
    assign pc_out   = pc_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start) |=> $stable(op_q));

    // R1
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_q == $past(sp_q) - 1'b1));

    // R2
    pull_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mem_addr[ADDR_W-1:SP_W] == STACK_PAGE) |=> (sp_q == $past(sp_q) + 1'b1));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

endmodule

// File: tb/test_stk_call_unit.sv
module test_stk_call_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [7:0]  sp_in = 8'h00, acc_in = 8'h00, stat_in = 8'h00;
    logic [15:0] pc_in = 16'h0000, target = 16'h0000;
    logic        busy, done, mem_we, mem_re;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, mem_rdata, sp_out, acc_out, stat_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    stk_call_unit i_stk_call_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .sp_in(sp_in), .acc_in(acc_in), .stat_in(stat_in),
        .pc_in(pc_in), .target(target), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sp_out(sp_out), .acc_out(acc_out), .stat_out(stat_out), .pc_out(pc_out)
    );

    // Memory model: stack page plus the two vector bytes.
    logic [7:0] stk [256];
    logic [7:0] vec_lo = 8'h34, vec_hi = 8'hC0;

    assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                       (mem_addr == 16'hFFFE)    ? vec_lo :
                       (mem_addr == 16'hFFFF)    ? vec_hi : 8'h00;

    always @(posedge clk)
        if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
    } access_t;

    access_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic exp_wr(input logic [15:0] a, input logic [7:0] d);
        access_t e;
        e.we = 1'b1; e.addr = a; e.data = d;
        exp_q.push_back(e);
    endtask

    task automatic exp_rd(input logic [15:0] a);
        access_t e;
        e.we = 1'b0; e.addr = a; e.data = 8'h00;
        exp_q.push_back(e);
    endtask

    // Monitor: compare every access against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && (mem_we || mem_re)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected access addr", {16'h0, mem_addr}, 32'h0);
            end else begin
                access_t e;
                e = exp_q.pop_front();
                chk(mem_we == e.we, "R9", "access direction", {31'h0, mem_we}, {31'h0, e.we});
                chk(mem_addr == e.addr, "R1/R2", "access address", {16'h0, mem_addr}, {16'h0, e.addr});
                if (e.we)
                    chk(mem_wdata == e.data, "R3/R5/R8", "write data", {24'h0, mem_wdata}, {24'h0, e.data});
            end
        end
    end

    task automatic run_op(input logic [2:0] o, input logic [7:0] sp, input logic [7:0] a,
                          input logic [7:0] st, input logic [15:0] pc, input logic [15:0] tg,
                          input int n_acc, input int hold,
                          input logic [7:0] e_sp, input logic [7:0] e_acc,
                          input logic [7:0] e_st, input logic [15:0] e_pc, input string req);
        int cnt;
        @(negedge clk);
        start = 1'b1; op = o; sp_in = sp; acc_in = a; stat_in = st; pc_in = pc; target = tg;
        cnt = 0;
        while (cnt < 40) begin
            @(negedge clk);
            cnt++;
            if (cnt >= hold) begin
                start = 1'b0;
            end else begin
                op = 3'd0;          // R10: a different operation offered while busy
                acc_in = ~a;
            end
            if (done) break;
        end
        chk(cnt == n_acc + 1, "R9", {req, " cycles to done"}, cnt, n_acc + 1);
        chk(sp_out == e_sp, req, "sp_out", {24'h0, sp_out}, {24'h0, e_sp});
        chk(acc_out == e_acc, req, "acc_out", {24'h0, acc_out}, {24'h0, e_acc});
        chk(stat_out == e_st, req, "stat_out", {24'h0, stat_out}, {24'h0, e_st});
        chk(pc_out == e_pc, req, "pc_out", {16'h0, pc_out}, {16'h0, e_pc});
        chk(exp_q.size() == 0, req, "accesses left over", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!busy && !done, "R11", "busy/done after reset", {30'h0, busy, done}, 0);
        chk(!mem_we && !mem_re, "R11", "strobes after reset", {30'h0, mem_we, mem_re}, 0);

        // R1 push accumulator
        exp_wr(16'h0180, 8'h5A);
        run_op(3'd0, 8'h80, 8'h5A, 8'h00, 16'h1111, 16'h0, 1, 1, 8'h7F, 8'h5A, 8'h00, 16'h1111, "R1");
        // R1 push at SP 0x00 wraps
        exp_wr(16'h0100, 8'hA5);
        run_op(3'd0, 8'h00, 8'hA5, 8'h00, 16'h1111, 16'h0, 1, 1, 8'hFF, 8'hA5, 8'h00, 16'h1111, "R1");
        // R3 push status forces bits 5 and 4
        exp_wr(16'h0140, 8'hF3);
        run_op(3'd1, 8'h40, 8'h00, 8'hC3, 16'h1111, 16'h0, 1, 1, 8'h3F, 8'h00, 8'hC3, 16'h1111, "R3");
        // R4 pull A of 0x80 sets N, clears Z
        stk[8'h80] = 8'h80;
        exp_rd(16'h0180);
        run_op(3'd2, 8'h7F, 8'h11, 8'h02, 16'h1111, 16'h0, 1, 1, 8'h80, 8'h80, 8'h80, 16'h1111, "R4");
        // R4 pull A of 0x00 sets Z, clears N, keeps others
        stk[8'h11] = 8'h00;
        exp_rd(16'h0111);
        run_op(3'd2, 8'h10, 8'h11, 8'hC1, 16'h1111, 16'h0, 1, 1, 8'h11, 8'h00, 8'h43, 16'h1111, "R4");
        // R2 pull status at SP 0xFF wraps, loaded as is
        stk[8'h00] = 8'h5C;
        exp_rd(16'h0100);
        run_op(3'd3, 8'hFF, 8'h00, 8'hFF, 16'h1111, 16'h0, 1, 1, 8'h00, 8'h00, 8'h5C, 16'h1111, "R2");
        // R5 call pushes next PC minus one, high first
        exp_wr(16'h01F0, 8'h12);
        exp_wr(16'h01EF, 8'h35);
        run_op(3'd4, 8'hF0, 8'h00, 8'h00, 16'h1236, 16'h4000, 2, 1, 8'hEE, 8'h00, 8'h00, 16'h4000, "R5");
        // R6 return lands on the instruction after the call
        exp_rd(16'h01EF);
        exp_rd(16'h01F0);
        run_op(3'd5, 8'hEE, 8'h00, 8'h00, 16'h9999, 16'h0, 2, 1, 8'hF0, 8'h00, 8'h00, 16'h1236, "R6");
        // R6 plus-one wraps 0xFFFF to 0x0000
        stk[8'h21] = 8'hFF; stk[8'h22] = 8'hFF;
        exp_rd(16'h0121);
        exp_rd(16'h0122);
        run_op(3'd5, 8'h20, 8'h00, 8'h00, 16'h9999, 16'h0, 2, 1, 8'h22, 8'h00, 8'h00, 16'h0000, "R6");
        // R7 return from interrupt: status, low, high, no increment
        stk[8'h31] = 8'hA7; stk[8'h32] = 8'h78; stk[8'h33] = 8'h56;
        exp_rd(16'h0131);
        exp_rd(16'h0132);
        exp_rd(16'h0133);
        run_op(3'd6, 8'h30, 8'h00, 8'h00, 16'h9999, 16'h0, 3, 1, 8'h33, 8'h00, 8'hA7, 16'h5678, "R7");
        // R8 break, with start held and a different op offered (R10)
        exp_wr(16'h0150, 8'h20);
        exp_wr(16'h014F, 8'h01);
        exp_wr(16'h014E, 8'h35);
        exp_rd(16'hFFFE);
        exp_rd(16'hFFFF);
        run_op(3'd7, 8'h50, 8'h66, 8'h01, 16'h2000, 16'h0, 5, 3, 8'h4D, 8'h66, 8'h05, 16'hC034, "R8 R10");
        @(negedge clk);
        chk(!busy && !done, "R10", "idle after held start", {30'h0, busy, done}, 0);
        report();
    end

endmodule